// File: doc/BRIEF.md
# Three-Axis Data-Ready and Overrun Status Tracker

This block tracks the freshness of samples in a three-axis measurement stream. The acquisition logic pulses one input per axis when a new sample for that axis has been written. The bus interface pulses one input per axis when the high byte of that axis's output register is read. From these two sets of strobes the block keeps an 8-bit status word and an active-high interrupt.

The status word holds a fresh-data flag and an overwrite flag for each axis. It also holds a combined fresh-data flag and a combined overwrite flag. The per-axis flags clear on a read of that axis's high byte. The combined flags clear only once all three high bytes of the current set have been read.

The block also holds a live copy and a read-side copy of each axis sample. The read-side copy is refreshed only when the X high byte is read. A burst read that starts at X therefore sees one coherent set. Only reset clears any state, so both the flags and the data persist across idle periods of the acquisition side.

Top module: `xyz_ready_tracker`

## Requirements
- R1: After reset, status_o, irq_o and data_o are all zero.
- R2: The status_o bit layout is fixed. Bits [2:0] are the per-axis fresh flags (bit 0 X, bit 1 Y, bit 2 Z). Bit 3 is the combined fresh flag. Bits [6:4] are the per-axis overwrite flags (bit 4 X, bit 5 Y, bit 6 Z). Bit 7 is the combined overwrite flag.
- R3: An axis fresh flag is 1 in the cycle after a sample pulse for that axis. It returns to 0 in the cycle after a high-byte read of that axis, when no sample for that axis arrives in the same cycle.
- R4: An axis overwrite flag becomes 1 when a sample for that axis arrives while its fresh flag is 1. It clears together with that axis fresh flag on a high-byte read.
- R5: The combined fresh flag becomes 1 after any sample pulse. It returns to 0 only in the cycle after the last of the three high bytes (X, Y and Z, in any order) has been read since the most recent sample pulse.
- R6: The combined overwrite flag becomes 1 when any axis overwrite event occurs. It clears in the same cycle as the combined fresh flag.
- R7: irq_o is always equal to the combined fresh flag (status_o bit 3).
- R8: data_o changes only in the cycle after an X high-byte read. It then holds the newest samples captured before that read. A read of the Y or Z high byte leaves data_o unchanged.
- R9: When a sample pulse and a clearing read for the same axis fall in the same cycle, the sample wins. The fresh flag stays 1, and an overwrite is recorded if the flag was already 1.
- R10: A sample pulse on any axis discards the record of high bytes read so far. All three high bytes must be read again before the combined flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_done_i | input | 3 | Per-axis sample written pulse (bit 0 X, 1 Y, 2 Z) |
| smp_data_i | input | 3*DATA_W | New sample values, axis i at [i*DATA_W +: DATA_W] |
| rd_hi_i | input | 3 | Per-axis high-byte read strobe (bit 0 X, 1 Y, 2 Z) |
| status_o | output | 8 | Status word laid out as in R2 |
| irq_o | output | 1 | Active-high interrupt, equals combined fresh flag |
| data_o | output | 3*DATA_W | Read-side sample copy, same packing as smp_data_i |

## Verification
The embedded assertions check several rules on every cycle:
- A sample always leaves its fresh flag set in the next cycle.
- An overwrite event sets the overwrite flag.
- No overwrite flag is ever set without its fresh flag.
- The combined flags never drop without a high-byte read.
- The read-side data never moves without an X read.

Only the bench scenarios can show the following:
- The exact clearing point after all three reads.
- The restart of read tracking when a sample lands between reads.
- The coherence of the captured set across a burst.
- The set-over-clear priority combined with the resulting status value.

// File: rtl/xyz_ready_pkg.sv
package xyz_ready_pkg;
  localparam int unsigned NUM_AXES = 3;

  // Layout must match the status word contract (bit 7 down to bit 0).
  typedef struct packed {
    logic                all_ow;
    logic [NUM_AXES-1:0] ow;
    logic                all_dr;
    logic [NUM_AXES-1:0] dr;
  } status_t;
endpackage

// File: rtl/xyz_axis_flags.sv
module xyz_axis_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic rd_i,
  output logic dr_o,
  output logic ow_o,
  output logic ow_evt_o
);
  logic dr_q, ow_q;

  assign ow_evt_o = done_i & dr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q <= 1'b0;
      ow_q <= 1'b0;
    end else if (done_i) begin
      dr_q <= 1'b1;
      ow_q <= ow_q | dr_q;
    end else if (rd_i) begin
      dr_q <= 1'b0;
      ow_q <= 1'b0;
    end
  end

  assign dr_o = dr_q;
  assign ow_o = ow_q;

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> dr_o);
  p_read_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> (!dr_o && !ow_o));
  p_ow_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && dr_o) |=> ow_o);
  p_ow_implies_dr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ow_o |-> dr_o);
endmodule

// File: rtl/xyz_set_tracker.sv
module xyz_set_tracker #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] rd_i,
  input  logic [N-1:0] ow_evt_i,
  output logic         all_dr_o,
  output logic         all_ow_o
);
  logic         all_dr_q, all_ow_q;
  logic [N-1:0] seen_q, seen_d;
  logic         any_new;

  assign any_new = |done_i;
  assign seen_d  = seen_q | rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      all_dr_q <= 1'b0;
      all_ow_q <= 1'b0;
      seen_q   <= '0;
    end else if (any_new) begin
      // new set begins: reads so far belong to the old set
      all_dr_q <= 1'b1;
      all_ow_q <= all_ow_q | (|ow_evt_i);
      seen_q   <= '0;
    end else begin
      seen_q <= seen_d;
      if (&seen_d) begin
        all_dr_q <= 1'b0;
        all_ow_q <= 1'b0;
      end
    end
  end

  assign all_dr_o = all_dr_q;
  assign all_ow_o = all_ow_q;

  p_any_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_i) |=> all_dr_o);
  p_hold_no_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_dr_o && !(|rd_i)) |=> all_dr_o);
  p_ow_with_dr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_ow_o |-> all_dr_o);
  p_ow_evt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ow_evt_i) |=> all_ow_o);
endmodule

// File: rtl/xyz_shadow_regs.sv
module xyz_shadow_regs #(
  parameter int unsigned N      = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      done_i,
  input  logic [N*DATA_W-1:0] data_i,
  input  logic              rd_x_i,
  output logic [N*DATA_W-1:0] data_o
);
  logic [N*DATA_W-1:0] live_q, shad_q;

  for (genvar g = 0; g < N; g++) begin : g_live
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        live_q[g*DATA_W +: DATA_W] <= '0;
      else if (done_i[g]) live_q[g*DATA_W +: DATA_W] <= data_i[g*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shad_q <= '0;
    else if (rd_x_i) shad_q <= live_q;
  end

  assign data_o = shad_q;

  p_hold_no_x_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_x_i |=> $stable(data_o));
endmodule

// File: rtl/xyz_ready_tracker.sv
module xyz_ready_tracker
  import xyz_ready_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_AXES-1:0]        smp_done_i,
  input  logic [NUM_AXES*DATA_W-1:0] smp_data_i,
  input  logic [NUM_AXES-1:0]        rd_hi_i,
  output logic [7:0]                 status_o,
  output logic                       irq_o,
  output logic [NUM_AXES*DATA_W-1:0] data_o
);
  status_t             st;
  logic [NUM_AXES-1:0] dr, ow, ow_evt;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    xyz_axis_flags u_flags (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .done_i   (smp_done_i[a]),
      .rd_i     (rd_hi_i[a]),
      .dr_o     (dr[a]),
      .ow_o     (ow[a]),
      .ow_evt_o (ow_evt[a])
    );
  end

  xyz_set_tracker #(.N(NUM_AXES)) u_set (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (smp_done_i),
    .rd_i     (rd_hi_i),
    .ow_evt_i (ow_evt),
    .all_dr_o (st.all_dr),
    .all_ow_o (st.all_ow)
  );

  xyz_shadow_regs #(.N(NUM_AXES), .DATA_W(DATA_W)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (smp_done_i),
    .data_i (smp_data_i),
    .rd_x_i (rd_hi_i[0]),
    .data_o (data_o)
  );

  assign st.dr    = dr;
  assign st.ow    = ow;
  assign status_o = st;
  assign irq_o    = st.all_dr;

  p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|smp_done_i));
  p_axis_needs_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_o[2:0]) |-> status_o[3]);
endmodule

// File: tb/tb_xyz_ready_tracker.sv
module tb_xyz_ready_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NA = 3;

  typedef struct {
    logic [7:0]       st;
    logic             irq;
    logic [NA*DW-1:0] dat;
    string            tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NA-1:0]    done = '0;
  logic [NA*DW-1:0] sdata = '0;
  logic [NA-1:0]    rd = '0;
  logic [7:0]       status;
  logic             irq;
  logic [NA*DW-1:0] dout;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  item_t q[$];

  // spec model state
  logic [NA-1:0]    m_dr = '0, m_ow = '0, m_seen = '0;
  logic             m_adr = 1'b0, m_aow = 1'b0;
  logic [NA*DW-1:0] m_live = '0, m_shad = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xyz_ready_tracker #(.DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_done_i(done), .smp_data_i(sdata),
    .rd_hi_i(rd), .status_o(status), .irq_o(irq), .data_o(dout)
  );

  task automatic check(input logic [7:0] st, input logic ir, input logic [NA*DW-1:0] dt,
                       input string tag);
    checks++;
    if (status !== st || irq !== ir || dout !== dt) begin
      errors++;
      $display("FAIL %s: status=%h irq=%b data=%h expected status=%h irq=%b data=%h",
               tag, status, irq, dout, st, ir, dt);
    end
  endtask

  // driver: one cycle of stimulus, expected result queued
  task automatic step(input logic [NA-1:0] d, input logic [NA-1:0] r,
                      input logic [NA*DW-1:0] v, input string tag);
    item_t it;
    logic [NA-1:0] nseen;
    @(negedge clk);
    done = d; rd = r; sdata = v;
    if (r[0]) m_shad = m_live;
    for (int i = 0; i < NA; i++) begin
      if (d[i]) begin
        m_ow[i] = m_ow[i] | m_dr[i];
        m_dr[i] = 1'b1;
        m_live[i*DW +: DW] = v[i*DW +: DW];
      end else if (r[i]) begin
        m_dr[i] = 1'b0;
        m_ow[i] = 1'b0;
      end
    end
    if (|d) begin
      m_aow  = m_aow | (|(d & m_dr_prev(d)));
      m_adr  = 1'b1;
      m_seen = '0;
    end else begin
      nseen = m_seen | r;
      m_seen = nseen;
      if (&nseen) begin m_adr = 1'b0; m_aow = 1'b0; end
    end
    it.st  = {m_aow, m_ow, m_adr, m_dr};
    it.irq = m_adr;
    it.dat = m_shad;
    it.tag = tag;
    q.push_back(it);
  endtask

  // per-axis overwrite events were captured into m_ow before this call
  logic [NA-1:0] ow_before;
  function automatic logic [NA-1:0] m_dr_prev(input logic [NA-1:0] d);
    return d & (m_ow ^ ow_before) | (d & ow_before & m_ow);
  endfunction

  task automatic s(input logic [NA-1:0] d, input logic [NA-1:0] r,
                   input logic [NA*DW-1:0] v, input string tag);
    ow_before = m_ow;
    // events are axes whose fresh flag was already set when the sample came
    step(d, r, v, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.st, it.irq, it.dat, it.tag);
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [NA*DW-1:0] A, B, C;

  initial begin
    A = {16'h3333, 16'h2222, 16'h1111};
    B = {16'hCCCC, 16'hBBBB, 16'hAAAA};
    C = {16'h0F0F, 16'h7E7E, 16'h5A5A};
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check(8'h00, 1'b0, '0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(8'h00, 1'b0, '0, "R1 after release");

    // X only, then partial and full reads
    s(3'b001, 3'b000, A, "R3 R2 R7 X fresh");
    s(3'b000, 3'b001, A, "R3 X read clears axis flag");
    s(3'b000, 3'b000, A, "R5 combined held after X read");
    s(3'b000, 3'b010, A, "R5 Y read");
    s(3'b000, 3'b100, A, "R5 R7 Z read completes set");

    // all axes together, burst read
    s(3'b111, 3'b000, A, "R2 R5 all axes fresh");
    s(3'b000, 3'b001, A, "R8 X read refreshes data");
    s(3'b000, 3'b010, A, "R3 Y read");
    s(3'b000, 3'b100, A, "R5 set complete");

    // overwrite on X
    s(3'b001, 3'b000, B, "R4 first X");
    s(3'b001, 3'b000, B, "R4 R6 X overwritten");
    s(3'b100, 3'b000, B, "R2 Z fresh, no Z overwrite");
    s(3'b000, 3'b001, B, "R4 X read clears overwrite");
    s(3'b000, 3'b010, B, "R6 combined overwrite held");
    s(3'b000, 3'b100, B, "R6 clears with combined fresh");

    // Y/Z reads do not refresh data
    s(3'b111, 3'b000, C, "R8 new set");
    s(3'b000, 3'b010, C, "R8 Y read keeps old data");
    s(3'b000, 3'b100, C, "R8 Z read keeps old data");
    s(3'b000, 3'b001, C, "R8 X read captures newest");

    // set beats clear
    s(3'b010, 3'b000, A, "R9 Y fresh");
    s(3'b010, 3'b010, B, "R9 sample wins over Y read");
    s(3'b000, 3'b001, B, "R8 X read takes Y update");
    s(3'b000, 3'b010, B, "R3 Y read");
    s(3'b000, 3'b100, B, "R5 complete");

    // restart of read tracking
    s(3'b001, 3'b000, C, "R10 set begins");
    s(3'b000, 3'b010, C, "R10 Y read");
    s(3'b000, 3'b100, C, "R10 Z read");
    s(3'b100, 3'b000, A, "R10 new Z sample restarts tracking");
    s(3'b000, 3'b001, A, "R10 X read");
    s(3'b000, 3'b000, A, "R10 still pending");
    s(3'b000, 3'b010, A, "R10 Y read again");
    s(3'b000, 3'b100, A, "R10 Z read again clears");
    s(3'b000, 3'b000, A, "R1 quiet");

    @(negedge clk);
    done = '0; rd = '0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule